// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Unit

This unit sits between an interrupt arbiter and the processor-facing register logic of an interrupt controller. It answers acknowledge requests, tracks which interrupt is running and at what priority, and services end-of-interrupt writes. Nested preemption is recorded as a linked list: each interrupt ID has one predecessor slot that holds the ID that was running when it was taken.

An acknowledge takes the arbiter's highest-pending ID only when that ID's priority is strictly more urgent (numerically lower) than the running priority. The taken ID becomes the running interrupt, and its pending bit is cleared through a one-cycle pulse. An end-of-interrupt either pops the running interrupt back to its predecessor in one cycle, or, when it names an interrupt deeper in the nest, walks the chain one link per clock to unlink that entry. While the walk runs, a busy flag is high and new requests are dropped.

Top module: `ackn_nest_unit`

## Requirements
- R1: An acknowledge is refused when the highest-pending ID is 1023, is at or above NUM_IRQ, or has a priority not strictly below the running priority. A refused acknowledge answers `ack_vld_o`=1 with `ack_id_o`=1023 one cycle after the request and changes no state.
- R2: A granted acknowledge answers one cycle after the request with `ack_vld_o`=1 and `ack_id_o` equal to the highest-pending ID. In that same cycle `run_id_o` takes that ID, `run_prio_o` takes its priority, and bit ID of `pend_clr_o` pulses high for one cycle. The ID previously running is stored as the new ID's predecessor.
- R3: `run_prio_o` is 0x100 whenever `run_id_o` is 1023; otherwise it is the priority the running ID had when it became running.
- R4: An end-of-interrupt accepted while `run_id_o` is 1023 changes nothing and pulses no `pend_set_o` bit.
- R5: An accepted end-of-interrupt for an ID below NUM_IRQ, while an interrupt is running, pulses bit ID of `pend_set_o` one cycle later when that ID is level-configured (`edge_cfg_i` bit 0), enabled and its input level is high.
- R6: Completing the running ID makes its predecessor the running ID one cycle later, with `run_prio_o` set to that predecessor's current priority, or 0x100 when the predecessor is 1023.
- R7: Completing a non-running ID walks from the running ID. The first node whose predecessor equals the completed ID has that predecessor replaced by the completed ID's predecessor. The walk ends at a predecessor of 1023 without changes. The running ID and priority do not change.
- R8: Only the low 10 bits of `eoi_data_i` name the completed ID; the upper bits have no effect.
- R9: A walk that visits N links keeps `busy_o` high for exactly N cycles after the accepting edge. Acknowledge and end-of-interrupt requests seen while `busy_o` is high are dropped with no response.
- R10: When an acknowledge and an end-of-interrupt are requested in the same idle cycle, the end-of-interrupt is served and the acknowledge is answered with 1023.
- R11: After reset, `run_id_o`=1023, `run_prio_o`=0x100, `busy_o`=0, `ack_vld_o`=0, no pulses are active, and every predecessor slot holds 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_id_i | input | 10 | Highest-pending ID from the arbiter, 1023 for none |
| prio_tab_i | input | NUM_IRQ*PRIO_W | Per-ID priority table, ID k at bits k*PRIO_W upward |
| edge_cfg_i | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| src_en_i | input | NUM_IRQ | Per-ID enable |
| src_lvl_i | input | NUM_IRQ | Per-ID input level |
| ack_req_i | input | 1 | Acknowledge request strobe |
| eoi_req_i | input | 1 | End-of-interrupt request strobe |
| eoi_data_i | input | EOI_W | End-of-interrupt write data |
| ack_vld_o | output | 1 | Acknowledge answer valid |
| ack_id_o | output | 10 | Acknowledged ID, 1023 when refused |
| pend_clr_o | output | NUM_IRQ | One-cycle pending clear pulses |
| pend_set_o | output | NUM_IRQ | One-cycle pending re-set pulses |
| run_id_o | output | 10 | Running interrupt ID |
| run_prio_o | output | PRIO_W+1 | Running priority |
| busy_o | output | 1 | Chain walk in progress |

## Verification
The bench builds the unit with its defaults: 96 IDs and 8-bit priorities. These values allow a priority of 0xFF to be granted against the idle level 0x100. They also allow arbiter IDs from 96 to 1022 to be offered so that their refusal can be tested. A four-deep nest reaches a three-link walk that unlinks the outermost interrupt. The bench checks that the unlinked entry is skipped on the final unwind. It also drives requests during the walk, a simultaneous acknowledge and completion, and a completion word with its upper bits set.

// File: rtl/ackn_pkg.sv
package ackn_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'h3FF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/ackn_prio_sel.sv
module ackn_prio_sel
  import ackn_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_IRQ*PRIO_W-1:0] tab_i,
  input  logic [ID_W-1:0]           id_i,
  output logic [PRIO_W:0]           prio_o
);
  // IDs outside the table map to the idle level, which never wins a compare
  always_comb begin
    prio_o = {1'b1, {PRIO_W{1'b0}}};
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (id_i == ID_W'(k)) prio_o = {1'b0, tab_i[k*PRIO_W +: PRIO_W]};
    end
  end
endmodule

// File: rtl/ackn_link_table.sv
module ackn_link_table
  import ackn_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [$clog2(NUM_IRQ)-1:0] waddr_i,
  input  logic [ID_W-1:0]            wdata_i,
  input  logic [ID_W-1:0]            raddr_a_i,
  output logic [ID_W-1:0]            rdata_a_o,
  input  logic [ID_W-1:0]            raddr_b_i,
  output logic [ID_W-1:0]            rdata_b_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [ID_W-1:0]    link_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] wr_sel;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sel
    assign wr_sel[g] = we_i && (waddr_i == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_IRQ; k++) link_q[k] <= SPUR_ID;
    end else begin
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (wr_sel[k]) link_q[k] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_a_o = SPUR_ID;
    rdata_b_o = SPUR_ID;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (raddr_a_i == ID_W'(k)) rdata_a_o = link_q[k];
      if (raddr_b_i == ID_W'(k)) rdata_b_o = link_q[k];
    end
  end
endmodule

// File: rtl/ackn_nest_unit.sv
module ackn_nest_unit
  import ackn_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int EOI_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ID_W-1:0]           hp_id_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_tab_i,
  input  logic [NUM_IRQ-1:0]        edge_cfg_i,
  input  logic [NUM_IRQ-1:0]        src_en_i,
  input  logic [NUM_IRQ-1:0]        src_lvl_i,
  input  logic                      ack_req_i,
  input  logic                      eoi_req_i,
  input  logic [EOI_W-1:0]          eoi_data_i,
  output logic                      ack_vld_o,
  output logic [ID_W-1:0]           ack_id_o,
  output logic [NUM_IRQ-1:0]        pend_clr_o,
  output logic [NUM_IRQ-1:0]        pend_set_o,
  output logic [ID_W-1:0]           run_id_o,
  output logic [PRIO_W:0]           run_prio_o,
  output logic                      busy_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [PRIO_W:0] RP_IDLE = {1'b1, {PRIO_W{1'b0}}};

  walk_st_e           state_q, state_d;
  logic [ID_W-1:0]    run_id_q, run_id_d;
  logic [PRIO_W:0]    run_prio_q, run_prio_d;
  logic [ID_W-1:0]    cursor_q, cursor_d;
  logic [ID_W-1:0]    target_q, target_d;
  logic               ack_vld_q, ack_vld_d;
  logic [ID_W-1:0]    ack_id_q, ack_id_d;
  logic [NUM_IRQ-1:0] pclr_q, pclr_d;
  logic [NUM_IRQ-1:0] pset_q, pset_d;

  logic               lk_we;
  logic [IDX_W-1:0]   lk_waddr;
  logic [ID_W-1:0]    lk_wdata;
  logic [ID_W-1:0]    lk_ra, lk_rd;
  logic [ID_W-1:0]    lk_rb, lk_rdb;
  logic [PRIO_W:0]    cand_prio, pred_prio;
  logic [ID_W-1:0]    eoi_id;
  logic [IDX_W-1:0]   eoi_idx;
  logic               eoi_hi_unused;

  assign eoi_id        = eoi_data_i[ID_W-1:0];
  assign eoi_idx       = eoi_id[IDX_W-1:0];
  assign eoi_hi_unused = ^eoi_data_i[EOI_W-1:ID_W];

  ackn_prio_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cand_prio (
    .tab_i  (prio_tab_i),
    .id_i   (hp_id_i),
    .prio_o (cand_prio)
  );

  ackn_prio_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pred_prio (
    .tab_i  (prio_tab_i),
    .id_i   (lk_rd),
    .prio_o (pred_prio)
  );

  ackn_link_table #(.NUM_IRQ(NUM_IRQ)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (lk_we),
    .waddr_i   (lk_waddr),
    .wdata_i   (lk_wdata),
    .raddr_a_i (lk_ra),
    .rdata_a_o (lk_rd),
    .raddr_b_i (lk_rb),
    .rdata_b_o (lk_rdb)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    cursor_d   = cursor_q;
    target_d   = target_q;
    ack_vld_d  = 1'b0;
    ack_id_d   = SPUR_ID;
    pclr_d     = '0;
    pset_d     = '0;
    lk_we      = 1'b0;
    lk_waddr   = '0;
    lk_wdata   = SPUR_ID;
    lk_ra      = run_id_q;
    lk_rb      = target_q;

    unique case (state_q)
      ST_IDLE: begin
        if (eoi_req_i) begin
          ack_vld_d = ack_req_i;
          if (run_id_q != SPUR_ID) begin
            if (eoi_id < ID_W'(NUM_IRQ)) begin
              if (!edge_cfg_i[eoi_idx] && src_en_i[eoi_idx] && src_lvl_i[eoi_idx])
                pset_d[eoi_idx] = 1'b1;
            end
            if (eoi_id == run_id_q) begin
              run_id_d   = lk_rd;
              run_prio_d = pred_prio;
            end else begin
              state_d  = ST_WALK;
              cursor_d = run_id_q;
              target_d = eoi_id;
            end
          end
        end else if (ack_req_i) begin
          ack_vld_d = 1'b1;
          if (cand_prio < run_prio_q) begin
            ack_id_d   = hp_id_i;
            run_id_d   = hp_id_i;
            run_prio_d = cand_prio;
            lk_we      = 1'b1;
            lk_waddr   = hp_id_i[IDX_W-1:0];
            lk_wdata   = run_id_q;
            pclr_d[hp_id_i[IDX_W-1:0]] = 1'b1;
          end
        end
      end
      ST_WALK: begin
        lk_ra = cursor_q;
        if (lk_rd == SPUR_ID) begin
          state_d = ST_IDLE;
        end else if (lk_rd == target_q) begin
          lk_we    = 1'b1;
          lk_waddr = cursor_q[IDX_W-1:0];
          lk_wdata = lk_rdb;
          state_d  = ST_IDLE;
        end else begin
          cursor_d = lk_rd;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      run_id_q   <= SPUR_ID;
      run_prio_q <= RP_IDLE;
      cursor_q   <= SPUR_ID;
      target_q   <= SPUR_ID;
      ack_vld_q  <= 1'b0;
      ack_id_q   <= SPUR_ID;
      pclr_q     <= '0;
      pset_q     <= '0;
    end else begin
      state_q    <= state_d;
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
      cursor_q   <= cursor_d;
      target_q   <= target_d;
      ack_vld_q  <= ack_vld_d;
      ack_id_q   <= ack_id_d;
      pclr_q     <= pclr_d;
      pset_q     <= pset_d;
    end
  end

  assign ack_vld_o  = ack_vld_q;
  assign ack_id_o   = ack_id_q;
  assign pend_clr_o = pclr_q;
  assign pend_set_o = pset_q;
  assign run_id_o   = run_id_q;
  assign run_prio_o = run_prio_q;
  assign busy_o     = (state_q == ST_WALK);

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_q && ack_id_q == SPUR_ID) |-> (pclr_q == '0)); // R1
  AST_GRANT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_q && ack_id_q != SPUR_ID) |-> (run_id_q == ack_id_q && $onehot(pclr_q))); // R2
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pclr_q)); // R2
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q == SPUR_ID) |-> (run_prio_q == RP_IDLE)); // R3
  AST_RUN_PRIO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q != SPUR_ID) |-> !run_prio_q[PRIO_W]); // R3
  AST_EOI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && eoi_req_i && run_id_q == SPUR_ID)
      |=> (run_id_q == SPUR_ID && pset_q == '0 && state_q == ST_IDLE)); // R4
  AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WALK) |=> (run_id_q == $past(run_id_q) && !ack_vld_q)); // R9
endmodule

// File: tb/ackn_nest_unit_tb.sv
module ackn_nest_unit_tb_top;
  localparam int  NUM_IRQ = 96;
  localparam int  PRIO_W  = 8;
  localparam int  EOI_W   = 32;
  localparam time CLK_PER = 10ns;
  localparam int  SPUR    = 1023;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [9:0]                hp_id_i = 10'h3FF;
  logic [NUM_IRQ*PRIO_W-1:0] prio_tab_i = '1;
  logic [NUM_IRQ-1:0]        edge_cfg_i = '0;
  logic [NUM_IRQ-1:0]        src_en_i = '0;
  logic [NUM_IRQ-1:0]        src_lvl_i = '0;
  logic                      ack_req_i = 1'b0;
  logic                      eoi_req_i = 1'b0;
  logic [EOI_W-1:0]          eoi_data_i = '0;
  logic                      ack_vld_o;
  logic [9:0]                ack_id_o;
  logic [NUM_IRQ-1:0]        pend_clr_o;
  logic [NUM_IRQ-1:0]        pend_set_o;
  logic [9:0]                run_id_o;
  logic [PRIO_W:0]           run_prio_o;
  logic                      busy_o;

  ackn_nest_unit #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .EOI_W(EOI_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hp_id_i(hp_id_i), .prio_tab_i(prio_tab_i),
    .edge_cfg_i(edge_cfg_i), .src_en_i(src_en_i), .src_lvl_i(src_lvl_i),
    .ack_req_i(ack_req_i), .eoi_req_i(eoi_req_i), .eoi_data_i(eoi_data_i),
    .ack_vld_o(ack_vld_o), .ack_id_o(ack_id_o), .pend_clr_o(pend_clr_o),
    .pend_set_o(pend_set_o), .run_id_o(run_id_o), .run_prio_o(run_prio_o),
    .busy_o(busy_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input longint act, input longint exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run = SPUR, m_rp = 256, m_busy = 0, m_ackv = 0, m_ackid = SPUR;
  int m_pred [NUM_IRQ];
  logic [NUM_IRQ-1:0] m_clr = '0, m_set = '0;

  function automatic int pr(int id);
    return int'(prio_tab_i[id*PRIO_W +: PRIO_W]);
  endfunction

  initial for (int k = 0; k < NUM_IRQ; k++) m_pred[k] = SPUR;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = SPUR; m_rp = 256; m_busy = 0; m_ackv = 0; m_ackid = SPUR;
      m_clr = '0; m_set = '0;
      for (int k = 0; k < NUM_IRQ; k++) m_pred[k] = SPUR;
    end else begin
      int id, hp, cur, nx, steps;
      m_ackv = 0; m_ackid = SPUR; m_clr = '0; m_set = '0;
      if (m_busy > 0) begin
        m_busy--;
      end else if (eoi_req_i) begin
        m_ackv = ack_req_i ? 1 : 0;
        id = int'(eoi_data_i) & 32'h3FF;
        if (m_run != SPUR) begin
          if (id < NUM_IRQ && !edge_cfg_i[id] && src_en_i[id] && src_lvl_i[id]) m_set[id] = 1'b1;
          if (id == m_run) begin
            nx = m_pred[m_run];
            m_run = nx;
            m_rp = (nx == SPUR) ? 256 : pr(nx);
          end else begin
            cur = m_run; steps = 0;
            forever begin
              steps++;
              nx = m_pred[cur];
              if (nx == SPUR) break;
              if (nx == id) begin m_pred[cur] = m_pred[id]; break; end
              cur = nx;
            end
            m_busy = steps;
          end
        end
      end else if (ack_req_i) begin
        m_ackv = 1;
        hp = int'(hp_id_i);
        if (hp < NUM_IRQ && pr(hp) < m_rp) begin
          m_ackid = hp;
          m_pred[hp] = m_run;
          m_run = hp;
          m_rp = pr(hp);
          m_clr[hp] = 1'b1;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ack_vld_o, m_ackv, "R1/R2 ack_vld");
      chk(ack_id_o, m_ackid, "R1/R2 ack_id");
      chk(run_id_o, m_run, "R6 run_id");
      chk(run_prio_o, m_rp, "R3 run_prio");
      chk(busy_o, (m_busy > 0), "R9 busy");
      chk(pend_clr_o != m_clr, 0, "R2 pend_clr");
      chk(pend_set_o != m_set, 0, "R5 pend_set");
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wait_idle(); while (busy_o) cyc(); endtask
  task automatic ack(input int id);
    hp_id_i = 10'(id); ack_req_i = 1'b1; cyc(); ack_req_i = 1'b0; cyc();
  endtask
  task automatic eoi(input logic [31:0] d);
    eoi_data_i = d; eoi_req_i = 1'b1; cyc(); eoi_req_i = 1'b0; cyc();
  endtask
  task automatic set_prio(input int id, input int p);
    prio_tab_i[id*PRIO_W +: PRIO_W] = PRIO_W'(p);
  endtask

  initial begin
    set_prio(5, 8'h40); set_prio(9, 8'h20); set_prio(12, 8'h10);
    set_prio(20, 8'h30); set_prio(21, 8'h30); set_prio(40, 8'h80);
    set_prio(60, 8'hFF);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R11 reset state
    chk(run_id_o, SPUR, "R11 reset run_id");
    chk(run_prio_o, 256, "R11 reset run_prio");
    chk(busy_o, 0, "R11 reset busy");
    chk(ack_vld_o, 0, "R11 reset ack_vld");

    ack(SPUR);                                  // R1 nothing pending
    ack(100);                                   // R1 ID out of range
    ack(60);                                    // R1/R2 0xFF beats 0x100
    chk(run_prio_o, 8'hFF, "R2 prio 0xFF granted");
    eoi(32'd60);                                // R6 back to idle
    chk(run_id_o, SPUR, "R6 unwind to none");
    ack(5);                                     // R2
    ack(20);                                    // R2 preempts 0x40
    ack(21);                                    // R1 equal priority refused
    chk(run_id_o, 20, "R1 equal prio refused");
    ack(40);                                    // R1 lower urgency refused
    ack(9);
    ack(12);                                    // chain 12>9>20>5
    // R7/R9 unlink outermost: three links, requests during walk dropped
    eoi_data_i = 32'd5; eoi_req_i = 1'b1; cyc(); eoi_req_i = 1'b0;
    hp_id_i = 10'd40; ack_req_i = 1'b1; cyc(); ack_req_i = 1'b0;
    chk(busy_o, 1, "R9 busy mid walk");
    wait_idle(); cyc();
    chk(run_id_o, 12, "R7 running unchanged by unlink");
    eoi(32'hABCD_0000 | 32'd12);                // R8 upper bits ignored
    chk(run_id_o, 9, "R8 masked completion");
    src_en_i[9] = 1'b1; src_lvl_i[9] = 1'b1;    // R5 level source still high
    eoi(32'd9);
    chk(run_id_o, 20, "R6 unwind to 20");
    // R10 both at once; R7 unlinked 5 is skipped
    hp_id_i = 10'd9; eoi_data_i = 32'd20; eoi_req_i = 1'b1; ack_req_i = 1'b1;
    cyc(); eoi_req_i = 1'b0; ack_req_i = 1'b0; cyc();
    chk(run_id_o, SPUR, "R7 unlinked entry skipped");
    src_en_i[5] = 1'b1; src_lvl_i[5] = 1'b1;
    eoi(32'd5);                                 // R4 ignored when idle
    chk(run_id_o, SPUR, "R4 idle completion ignored");
    ack(5); ack(9);
    eoi(32'd40); wait_idle(); cyc();            // R7 walk to end, no match
    edge_cfg_i[9] = 1'b1;
    eoi(32'd1023); wait_idle(); cyc();          // R7 completion of 1023
    eoi(32'd9);                                 // R5 edge source not re-set
    eoi(32'd5);
    chk(run_id_o, SPUR, "R6 nest emptied");
    repeat (3) cyc();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule